// File: doc/BRIEF.md
# Audio Clock Source Selection Controller

This controller decides where an audio converter's master clock comes from and which of its two crystal oscillators is powered. One oscillator serves the 48 kHz rate family and the other the 44.1 kHz family. With no external sync present, the configuration switches choose the family. When a valid external sync is present, the family always follows the rate code reported by the sync receiver.

Whenever the controller starts following a sync, or the sync changes family, it first routes the recovered receiver clock to the master clock multiplexer. It hands over to the local oscillator only after the disciplining PLL has shown a fresh lock for the newly chosen oscillator.

The single or double rate mode is taken from the switches alone, because the master clock frequency is the same in both modes. The sync-present and lock inputs are asynchronous and pass through a synchronizer. The sync observation is debounced before it is acted on. A lock that never arrives raises a timeout flag while the clock stays on the recovered source.

Top module: `aclk_source_ctrl`

## Requirements
- R1: While `rst` is high, both oscillator enables are 0, `mclk_use_osc` is 1, and `ext_following`, `lock_timeout`, `rate_unsupported` and `double_rate` are all 0.
- R2: With no external sync in effect, `fam_44k_active` follows `cfg_fam_44k` (1 = 44.1 kHz family, 0 = 48 kHz family), and the enable of that family's oscillator is the one that is set.
- R3: `osc48_en` and `osc44_en` are never both 1. When the selected family changes, both enables are 0 for exactly one cycle before the new one rises.
- R4: Rate codes 1, 3 and 5 (44.1k, 88.2k, 176.4k) select the 44.1 kHz family, and codes 2, 4 and 6 (48k, 96k, 192k) select the 48 kHz family. A double-rate code and a single-rate code of the same family give the same selection, and neither changes `double_rate`.
- R5: A sync that is present with a usable code (1 to 6) sets `ext_following`, and its family overrides `cfg_fam_44k`.
- R6: On entering external following, or on a family change while following, `mclk_use_osc` goes to 0. It returns to 1 only after the synchronized lock has been seen low and then high since that event, so a lock that stays high from before the event does not count.
- R7: While the sync is present with code 0 (32 kHz) or 7, `rate_unsupported` is 1, and the family, the oscillator enables and the clock source stay as they were.
- R8: When the sync goes away, the block drops external following, returns to the switch family and sets `mclk_use_osc` to 1.
- R9: A change of the sync-present flag or the rate code takes effect only after the new value has been sampled unchanged, after the two-flop synchronizer, on DEBOUNCE_CYCLES+1 consecutive clock edges. A shorter pulse is ignored.
- R10: If lock is not qualified within LOCK_TIMEOUT cycles of acquisition, `lock_timeout` becomes 1 while `mclk_use_osc` stays 0. The flag clears on qualified lock, on loss of sync or on a family change.
- R11: `double_rate` is `cfg_double_rate` delayed by one register, whatever the sync state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_fam_44k | input | 1 | Switch family: 1 = 44.1 kHz, 0 = 48 kHz |
| cfg_double_rate | input | 1 | Switch mode: 1 = double rate |
| ext_present_a | input | 1 | External sync detected (asynchronous) |
| ext_rate_code | input | 3 | Rate code from the sync receiver |
| pll_lock_a | input | 1 | Oscillator PLL lock (asynchronous) |
| osc48_en | output | 1 | Power enable, 48 kHz-family oscillator |
| osc44_en | output | 1 | Power enable, 44.1 kHz-family oscillator |
| mclk_use_osc | output | 1 | Master clock select: 1 = local oscillator, 0 = recovered clock |
| double_rate | output | 1 | Registered single/double mode |
| fam_44k_active | output | 1 | Family in use: 1 = 44.1 kHz |
| ext_following | output | 1 | Family is taken from the external sync |
| lock_timeout | output | 1 | Lock did not arrive in time |
| rate_unsupported | output | 1 | Present sync carries an unusable code |

## Verification
The assertions assume that the switch inputs and the rate code are already synchronous to `clk`. They also assume that reset is held for several cycles, so that every `$past` value they read was set by reset. The bench drives every input on the falling edge, so the reference model sees exactly the values the design samples. Its pseudo-random stretch changes the inputs rarely enough that debounced states are reached and lock is qualified, while still producing glitches shorter than the debounce window and stale locks.

// File: rtl/aclk_pkg.sv
package aclk_pkg;

    localparam int unsigned CODE_W = 3;

    typedef enum logic [1:0] {
        ST_SWITCH  = 2'd0,
        ST_ACQUIRE = 2'd1,
        ST_LOCKED  = 2'd2
    } ctl_state_t;

    typedef enum logic {
        FAM_48K = 1'b0,
        FAM_44K = 1'b1
    } rate_fam_t;

    typedef struct packed {
        logic      usable;
        rate_fam_t fam;
    } rate_info_t;

    typedef struct packed {
        logic              present;
        logic [CODE_W-1:0] code;
    } sync_obs_t;

    // Codes 1..6 are usable; odd codes belong to the 44.1 kHz family.
    function automatic rate_info_t decode_rate(input logic [CODE_W-1:0] code);
        rate_info_t r;
        r.usable = (code != '0) && (code != '1);
        r.fam    = code[0] ? FAM_44K : FAM_48K;
        return r;
    endfunction

endpackage

// File: rtl/aclk_sync.sv
module aclk_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/aclk_debounce.sv
module aclk_debounce #(
    parameter int unsigned HOLD  = 1024,
    parameter int          WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] raw,
    output logic [WIDTH-1:0] stable
);
    localparam int CW = (HOLD < 2) ? 1 : $clog2(HOLD + 1);
    localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

    logic [WIDTH-1:0] cand_q;
    logic [WIDTH-1:0] stable_q;
    logic [CW-1:0]    run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cand_q   <= '0;
            stable_q <= '0;
            run_q    <= '0;
        end else if (raw != cand_q) begin
            cand_q <= raw;
            run_q  <= '0;
        end else if (run_q == LAST) begin
            stable_q <= cand_q;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end

    assign stable = stable_q;
endmodule

// File: rtl/aclk_ctl_fsm.sv
module aclk_ctl_fsm
    import aclk_pkg::*;
#(
    parameter int unsigned LOCK_TIMEOUT = 1 << 20
) (
    input  logic       clk,
    input  logic       rst,
    input  sync_obs_t  obs,
    input  logic       lock_s,
    input  rate_fam_t  cfg_fam,
    input  logic       cfg_double,
    output ctl_state_t state,
    output rate_fam_t  fam,
    output logic       timeout,
    output logic       unsupported,
    output logic       dbl
);
    localparam int TW = (LOCK_TIMEOUT < 2) ? 1 : $clog2(LOCK_TIMEOUT + 1);
    localparam logic [TW-1:0] T_LAST = TW'(LOCK_TIMEOUT - 1);

    ctl_state_t     state_q;
    rate_fam_t      fam_q;
    logic           armed_q;
    logic [TW-1:0]  timer_q;
    logic           timeout_q;
    logic           unsup_q;
    logic           dbl_q;
    rate_info_t     info;
    logic           fam_change;

    assign info       = decode_rate(obs.code);
    assign fam_change = info.usable && (info.fam != fam_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_SWITCH;
            fam_q     <= FAM_48K;
            armed_q   <= 1'b0;
            timer_q   <= '0;
            timeout_q <= 1'b0;
            unsup_q   <= 1'b0;
            dbl_q     <= 1'b0;
        end else begin
            unsup_q <= obs.present && !info.usable;
            dbl_q   <= cfg_double;
            unique case (state_q)
                ST_SWITCH: begin
                    if (obs.present && info.usable) begin
                        state_q   <= ST_ACQUIRE;
                        fam_q     <= info.fam;
                        armed_q   <= 1'b0;
                        timer_q   <= '0;
                        timeout_q <= 1'b0;
                    end else begin
                        fam_q <= cfg_fam;
                    end
                end
                ST_ACQUIRE: begin
                    if (!obs.present) begin
                        state_q   <= ST_SWITCH;
                        fam_q     <= cfg_fam;
                        timeout_q <= 1'b0;
                    end else if (fam_change) begin
                        fam_q     <= info.fam;
                        armed_q   <= 1'b0;
                        timer_q   <= '0;
                        timeout_q <= 1'b0;
                    end else if (armed_q && lock_s) begin
                        state_q   <= ST_LOCKED;
                        timeout_q <= 1'b0;
                    end else begin
                        if (!lock_s) armed_q <= 1'b1;
                        if (timer_q == T_LAST) timeout_q <= 1'b1;
                        else                   timer_q   <= timer_q + 1'b1;
                    end
                end
                ST_LOCKED: begin
                    if (!obs.present) begin
                        state_q <= ST_SWITCH;
                        fam_q   <= cfg_fam;
                    end else if (fam_change) begin
                        state_q   <= ST_ACQUIRE;
                        fam_q     <= info.fam;
                        armed_q   <= 1'b0;
                        timer_q   <= '0;
                        timeout_q <= 1'b0;
                    end
                end
                default: state_q <= ST_SWITCH;
            endcase
        end
    end

    assign state       = state_q;
    assign fam         = fam_q;
    assign timeout     = timeout_q;
    assign unsupported = unsup_q;
    assign dbl         = dbl_q;
endmodule

// File: rtl/aclk_osc_gate.sv
module aclk_osc_gate
    import aclk_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  rate_fam_t fam,
    output logic      en48,
    output logic      en44
);
    logic en48_q;
    logic en44_q;
    logic clash;

    assign clash = (en48_q && fam == FAM_44K) || (en44_q && fam == FAM_48K);

    always_ff @(posedge clk) begin
        if (rst || clash) begin
            en48_q <= 1'b0;
            en44_q <= 1'b0;
        end else begin
            en48_q <= (fam == FAM_48K);
            en44_q <= (fam == FAM_44K);
        end
    end

    assign en48 = en48_q;
    assign en44 = en44_q;
endmodule

// File: rtl/aclk_source_ctrl.sv
module aclk_source_ctrl
    import aclk_pkg::*;
#(
    parameter int unsigned DEBOUNCE_CYCLES = 1024,
    parameter int unsigned LOCK_TIMEOUT    = 1 << 20,
    parameter int          SYNC_STAGES     = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_fam_44k,
    input  logic                 cfg_double_rate,
    input  logic                 ext_present_a,
    input  logic [CODE_W-1:0]    ext_rate_code,
    input  logic                 pll_lock_a,
    output logic                 osc48_en,
    output logic                 osc44_en,
    output logic                 mclk_use_osc,
    output logic                 double_rate,
    output logic                 fam_44k_active,
    output logic                 ext_following,
    output logic                 lock_timeout,
    output logic                 rate_unsupported
);
    localparam int OBS_W = $bits(sync_obs_t);

    logic [1:0]       async_s;
    sync_obs_t        raw_obs;
    sync_obs_t        filt_obs;
    logic [OBS_W-1:0] filt_bits;
    ctl_state_t       state;
    rate_fam_t        fam;
    rate_fam_t        cfg_fam;

    aclk_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({ext_present_a, pll_lock_a}),
        .q   (async_s)
    );

    assign raw_obs = '{present: async_s[1], code: ext_rate_code};

    aclk_debounce #(.HOLD(DEBOUNCE_CYCLES), .WIDTH(OBS_W)) u_deb (
        .clk    (clk),
        .rst    (rst),
        .raw    (raw_obs),
        .stable (filt_bits)
    );

    assign filt_obs = sync_obs_t'(filt_bits);
    assign cfg_fam  = cfg_fam_44k ? FAM_44K : FAM_48K;

    aclk_ctl_fsm #(.LOCK_TIMEOUT(LOCK_TIMEOUT)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .obs         (filt_obs),
        .lock_s      (async_s[0]),
        .cfg_fam     (cfg_fam),
        .cfg_double  (cfg_double_rate),
        .state       (state),
        .fam         (fam),
        .timeout     (lock_timeout),
        .unsupported (rate_unsupported),
        .dbl         (double_rate)
    );

    aclk_osc_gate u_gate (
        .clk  (clk),
        .rst  (rst),
        .fam  (fam),
        .en48 (osc48_en),
        .en44 (osc44_en)
    );

    assign mclk_use_osc   = (state != ST_ACQUIRE);
    assign ext_following  = (state != ST_SWITCH);
    assign fam_44k_active = (fam == FAM_44K);
endmodule

// File: rtl/aclk_source_ctrl_chk.sv
module aclk_source_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic osc48_en,
    input logic osc44_en,
    input logic mclk_use_osc,
    input logic fam_44k_active,
    input logic ext_following,
    input logic lock_timeout,
    input logic rate_unsupported
);
    assert_no_overlap_R3: assert property (@(posedge clk) disable iff (rst)
        !(osc48_en && osc44_en));

    assert_gap_to_44_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(osc44_en) |-> !$past(osc48_en));

    assert_gap_to_48_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(osc48_en) |-> !$past(osc44_en));

    assert_start_on_recovered_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(ext_following) |-> !mclk_use_osc);

    assert_local_on_osc_R8: assert property (@(posedge clk) disable iff (rst)
        !ext_following |-> mclk_use_osc);

    assert_timeout_on_recovered_R10: assert property (@(posedge clk) disable iff (rst)
        lock_timeout |-> (!mclk_use_osc && ext_following));

    assert_unusable_holds_family_R7: assert property (@(posedge clk) disable iff (rst)
        (rate_unsupported && ext_following && $past(ext_following)) |-> $stable(fam_44k_active));
endmodule

bind aclk_source_ctrl aclk_source_ctrl_chk u_chk (
    .clk              (clk),
    .rst              (rst),
    .osc48_en         (osc48_en),
    .osc44_en         (osc44_en),
    .mclk_use_osc     (mclk_use_osc),
    .fam_44k_active   (fam_44k_active),
    .ext_following    (ext_following),
    .lock_timeout     (lock_timeout),
    .rate_unsupported (rate_unsupported)
);

// File: tb/aclk_source_ctrl_test.sv
`timescale 1ns/1ps
module aclk_source_ctrl_test;
    localparam int DEB = 4;
    localparam int TMO = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_fam_44k = 1'b0;
    logic cfg_double_rate = 1'b0;
    logic ext_present_a = 1'b0;
    logic [2:0] ext_rate_code = 3'd0;
    logic pll_lock_a = 1'b0;
    logic osc48_en, osc44_en, mclk_use_osc, double_rate;
    logic fam_44k_active, ext_following, lock_timeout, rate_unsupported;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    aclk_source_ctrl #(.DEBOUNCE_CYCLES(DEB), .LOCK_TIMEOUT(TMO)) uut (
        .clk (clk), .rst (rst),
        .cfg_fam_44k (cfg_fam_44k), .cfg_double_rate (cfg_double_rate),
        .ext_present_a (ext_present_a), .ext_rate_code (ext_rate_code),
        .pll_lock_a (pll_lock_a),
        .osc48_en (osc48_en), .osc44_en (osc44_en), .mclk_use_osc (mclk_use_osc),
        .double_rate (double_rate), .fam_44k_active (fam_44k_active),
        .ext_following (ext_following), .lock_timeout (lock_timeout),
        .rate_unsupported (rate_unsupported)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit        pres_pipe[$];
    bit        lock_pipe[$];
    bit [3:0]  history[$];
    bit [3:0]  m_filt;
    int        m_mode;          // 0 switch, 1 acquiring, 2 on oscillator
    bit        m_fam;           // 1 = 44.1k family
    bit        m_seen_low;
    int        m_acq_cycles;
    bit        m_to, m_uns, m_dbl, m_e48, m_e44;
    bit        p_old, l_old, f_pres, f_use, f_fam, all_same, clash;
    bit [3:0]  smp;

    function automatic bit usable(input bit [2:0] c);
        return (c >= 3'd1) && (c <= 3'd6);
    endfunction

    function automatic bit fam_of(input bit [2:0] c);
        return (c == 3'd1) || (c == 3'd3) || (c == 3'd5);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            pres_pipe = '{0, 0};
            lock_pipe = '{0, 0};
            history.delete();
            history.push_back(4'd0);
            m_filt = 0; m_mode = 0; m_fam = 0; m_seen_low = 0; m_acq_cycles = 0;
            m_to = 0; m_uns = 0; m_dbl = 0; m_e48 = 0; m_e44 = 0;
        end else begin
            p_old = pres_pipe[0];
            l_old = lock_pipe[0];
            // oscillator enables from the previous family choice
            clash = (m_e48 && m_fam) || (m_e44 && !m_fam);
            if (clash) begin m_e48 = 0; m_e44 = 0; end
            else begin m_e48 = !m_fam; m_e44 = m_fam; end
            // controller decisions on the previous debounced view
            f_pres = m_filt[3];
            f_use  = usable(m_filt[2:0]);
            f_fam  = fam_of(m_filt[2:0]);
            m_uns  = f_pres && !f_use;
            m_dbl  = cfg_double_rate;
            if (m_mode == 0) begin
                if (f_pres && f_use) begin
                    m_mode = 1; m_fam = f_fam; m_seen_low = 0; m_acq_cycles = 0; m_to = 0;
                end else m_fam = cfg_fam_44k;
            end else if (!f_pres) begin
                m_mode = 0; m_fam = cfg_fam_44k; m_to = 0;
            end else if (f_use && f_fam != m_fam) begin
                m_mode = 1; m_fam = f_fam; m_seen_low = 0; m_acq_cycles = 0; m_to = 0;
            end else if (m_mode == 1) begin
                if (m_seen_low && l_old) begin
                    m_mode = 2; m_to = 0;
                end else begin
                    if (!l_old) m_seen_low = 1;
                    m_acq_cycles++;
                    if (m_acq_cycles >= TMO) m_to = 1;
                end
            end
            // debounce: last DEB+1 samples all equal
            smp = {p_old, ext_rate_code};
            history.push_back(smp);
            if (history.size() > DEB + 1) void'(history.pop_front());
            all_same = (history.size() == DEB + 1);
            foreach (history[i]) if (history[i] != smp) all_same = 0;
            if (all_same) m_filt = smp;
            // synchronizer shift
            void'(pres_pipe.pop_front()); pres_pipe.push_back(ext_present_a);
            void'(lock_pipe.pop_front()); lock_pipe.push_back(pll_lock_a);
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            chk("R3", "osc48_en", osc48_en, m_e48);
            chk("R3", "osc44_en", osc44_en, m_e44);
            chk("R6", "mclk_use_osc", mclk_use_osc, m_mode != 1);
            chk("R5", "ext_following", ext_following, m_mode != 0);
            chk("R2", "fam_44k_active", fam_44k_active, m_fam);
            chk("R11", "double_rate", double_rate, m_dbl);
            chk("R10", "lock_timeout", lock_timeout, m_to);
            chk("R7", "rate_unsupported", rate_unsupported, m_uns);
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        wait_cyc(3);
        // R1 reset state
        chk("R1", "osc48_en", osc48_en, 0);
        chk("R1", "osc44_en", osc44_en, 0);
        chk("R1", "mclk_use_osc", mclk_use_osc, 1);
        chk("R1", "ext_following", ext_following, 0);
        chk("R1", "flags", {lock_timeout, rate_unsupported, double_rate}, 0);
        rst = 1'b0;
        wait_cyc(10);
        chk("R2", "osc48_en on switch 48k", osc48_en, 1);
        // switch family change with one-cycle gap
        cfg_fam_44k = 1'b1;
        wait_cyc(2);
        chk("R3", "gap both off", {osc48_en, osc44_en}, 0);
        wait_cyc(1);
        chk("R3", "osc44 after gap", {osc48_en, osc44_en}, 1);
        chk("R2", "fam follows switch", fam_44k_active, 1);
        cfg_double_rate = 1'b1;
        wait_cyc(3);
        chk("R11", "double_rate", double_rate, 1);
        // external 96k code: 48k family overrides switch
        ext_present_a = 1'b1; ext_rate_code = 3'd4;
        wait_cyc(20);
        chk("R5", "ext_following", ext_following, 1);
        chk("R4", "96k -> 48k family", fam_44k_active, 0);
        chk("R4", "mode bit unchanged", double_rate, 1);
        chk("R6", "recovered clock while acquiring", mclk_use_osc, 0);
        pll_lock_a = 1'b1;
        wait_cyc(10);
        chk("R6", "oscillator after lock", mclk_use_osc, 1);
        // short loss of present is ignored
        ext_present_a = 1'b0;
        wait_cyc(3);
        ext_present_a = 1'b1;
        wait_cyc(20);
        chk("R9", "glitch on present ignored", {ext_following, mclk_use_osc}, 3);
        // short code glitch is ignored
        ext_rate_code = 3'd1;
        wait_cyc(3);
        ext_rate_code = 3'd4;
        wait_cyc(20);
        chk("R9", "glitch on code ignored", {fam_44k_active, mclk_use_osc}, 1);
        // 88.2k: family change, stale lock not accepted
        ext_rate_code = 3'd3;
        wait_cyc(20);
        chk("R4", "88.2k -> 44.1k family", fam_44k_active, 1);
        chk("R6", "stale lock rejected", mclk_use_osc, 0);
        pll_lock_a = 1'b0;
        wait_cyc(3);
        pll_lock_a = 1'b1;
        wait_cyc(10);
        chk("R6", "fresh lock accepted", mclk_use_osc, 1);
        // unusable codes
        ext_rate_code = 3'd7;
        wait_cyc(20);
        chk("R7", "code 7 flagged", rate_unsupported, 1);
        chk("R7", "code 7 keeps family", {fam_44k_active, osc44_en, mclk_use_osc}, 7);
        ext_rate_code = 3'd0;
        wait_cyc(20);
        chk("R7", "32k flagged", rate_unsupported, 1);
        chk("R7", "32k keeps family", {fam_44k_active, osc44_en, mclk_use_osc}, 7);
        ext_rate_code = 3'd5;
        wait_cyc(20);
        chk("R4", "176.4k same family no reacquire", {rate_unsupported, fam_44k_active, mclk_use_osc}, 3);
        // timeout path
        pll_lock_a = 1'b0;
        ext_rate_code = 3'd2;
        wait_cyc(20);
        chk("R10", "no timeout yet", {lock_timeout, mclk_use_osc}, 0);
        wait_cyc(40);
        chk("R10", "timeout raised", {lock_timeout, mclk_use_osc}, 2);
        pll_lock_a = 1'b1;
        wait_cyc(10);
        chk("R10", "timeout cleared by lock", {lock_timeout, mclk_use_osc}, 1);
        // loss of sync
        ext_present_a = 1'b0;
        wait_cyc(20);
        chk("R8", "back to switch", {ext_following, fam_44k_active, mclk_use_osc, osc44_en}, 7);
        // pseudo-random stretch checked by the model every cycle
        for (int i = 0; i < 2500; i++) begin
            if ($urandom_range(0, 39) == 0) ext_present_a = ~ext_present_a;
            if ($urandom_range(0, 29) == 0) ext_rate_code = 3'($urandom_range(0, 7));
            if ($urandom_range(0, 24) == 0) pll_lock_a = ~pll_lock_a;
            if ($urandom_range(0, 199) == 0) cfg_fam_44k = ~cfg_fam_44k;
            if ($urandom_range(0, 99) == 0) cfg_double_rate = ~cfg_double_rate;
            wait_cyc(1);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule